// File: doc/BRIEF.md
# Serial Clock Width-Pattern Reset Detector

This block lets a host reset a serial slave using nothing but the serial clock line. The detector brings the raw clock line into the master clock domain and times every high and every low phase in master clock cycles. If three high phases in a row fall inside three fixed width windows, with adequate low gaps between them, it raises a reset request for a single master clock cycle. The reset actions themselves are handled elsewhere.

Ordinary transfers run the serial clock at periods of only a few master cycles. Those phases are far shorter than any window, so a data burst never advances the detector. Chip select is not needed, because boards often tie it permanently active. The detector therefore ignores it and only reports its synchronised level for debug. An attempt is abandoned when any high phase misses its window, when a gap is too short, or when a gap runs longer than a timeout.

Top module: `sclk_reset_detector`

## Requirements
- R1: `sclk_in` passes through two flops before use. `dbg_state[2]` shows the synchronised level two master clock edges after the input changes.
- R2: When idle, a high phase of 300 to 500 cycles inclusive is accepted as the first step. `dbg_state[1:0]` becomes 1.
- R3: After an accepted high phase, the next low phase must last at least 5 cycles. A shorter low returns the detector to idle, and the high phase that follows is judged as a possible first step.
- R4: After the first step, a high phase of 550 to 750 cycles inclusive is accepted as the second step. `dbg_state[1:0]` becomes 2.
- R5: After the second step, a high phase of 1050 to 1250 cycles inclusive raises `rst_req` for exactly one cycle and returns the detector to idle. The request is high in the third master clock cycle after `sclk_in` falls.
- R6: A high phase outside the window of the current step returns the detector to idle. If that phase lies in 300 to 500, the detector instead goes to step 1.
- R7: A low phase longer than 2000 cycles (LOW_TIMEOUT) returns the detector to idle. A low phase of exactly 2000 cycles does not.
- R8: The phase counter saturates. A high phase longer than the counter range, such as 2448 cycles, is rejected and is never treated as a short phase.
- R9: `cs_n` has no effect on detection. `dbg_state[3]` shows the inverted `cs_n` level after two flops (1 = selected).
- R10: During and right after reset, `rst_req` is 0 and `dbg_state` is 0.
- R11: `dbg_state[1:0]` encodes progress as 0 = idle, 1 = one step accepted, 2 = two steps accepted. The value 3 never appears, and progress never jumps from 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select level, active low, may be tied low |
| sclk_in | input | 1 | Raw serial clock line |
| rst_req | output | 1 | One-cycle reset request |
| dbg_state | output | 4 | {selected, synced clock, progress[1:0]} |

## Verification
Two actions can happen on the same falling edge. A phase that misses the second or third window aborts the attempt, and in that same cycle the phase can start a new attempt if it fits the first window. The bench provokes this with sequences such as 400, 400, 600, 1100 and with random phases clustered around every window edge. A bench model replays each phase width and predicts the progress code and the running count of reset requests. The bench compares both against the outputs after every low gap of four or more cycles.

// File: rtl/sclk_reset_detector.sv
`timescale 1ns/1ps
module sclk_reset_detector #(
  parameter int H1_MIN      = 300,
  parameter int H1_MAX      = 500,
  parameter int H2_MIN      = 550,
  parameter int H2_MAX      = 750,
  parameter int H3_MIN      = 1050,
  parameter int H3_MAX      = 1250,
  parameter int LOW_MIN     = 5,
  parameter int LOW_TIMEOUT = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk_in,
  output logic       rst_req,
  output logic [3:0] dbg_state
);
  localparam int LONGEST = (H3_MAX > LOW_TIMEOUT) ? H3_MAX : LOW_TIMEOUT;
  localparam int CNT_MAX = LONGEST + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ONE = 2'd1, ST_TWO = 2'd2} stage_t;

  logic [1:0]       sclk_sync, cs_sync;
  logic             sclk_d;
  logic [CNT_W-1:0] cnt;
  stage_t           stage, stage_nx;
  logic             req_nx;

  wire sclk_s = sclk_sync[1];
  wire rise   = sclk_s & ~sclk_d;
  wire fall   = ~sclk_s & sclk_d;
  wire low_on = ~sclk_s & ~sclk_d;

  function automatic logic in_win(input logic [CNT_W-1:0] w, input int lo, input int hi);
    return (int'(w) >= lo) && (int'(w) <= hi);
  endfunction

  wire w1 = in_win(cnt, H1_MIN, H1_MAX);
  wire w2 = in_win(cnt, H2_MIN, H2_MAX);
  wire w3 = in_win(cnt, H3_MIN, H3_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= 2'b00;
      cs_sync   <= 2'b11;
      sclk_d    <= 1'b0;
    end else begin
      sclk_sync <= {sclk_sync[0], sclk_in};
      cs_sync   <= {cs_sync[0], cs_n};
      sclk_d    <= sclk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (rise || fall)
      cnt <= CNT_W'(1);
    else if (cnt != CNT_TOP)
      cnt <= cnt + 1'b1;
  end

  always_comb begin
    stage_nx = stage;
    req_nx   = 1'b0;
    if (rise) begin
      if (stage != ST_IDLE && int'(cnt) < LOW_MIN)
        stage_nx = ST_IDLE;
    end else if (fall) begin
      case (stage)
        ST_ONE:  stage_nx = w2 ? ST_TWO : (w1 ? ST_ONE : ST_IDLE);
        ST_TWO: begin
          if (w3) begin
            req_nx   = 1'b1;
            stage_nx = ST_IDLE;
          end else begin
            stage_nx = w1 ? ST_ONE : ST_IDLE;
          end
        end
        default: stage_nx = w1 ? ST_ONE : ST_IDLE;
      endcase
    end else if (low_on && stage != ST_IDLE && int'(cnt) >= LOW_TIMEOUT) begin
      stage_nx = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage   <= ST_IDLE;
      rst_req <= 1'b0;
    end else begin
      stage   <= stage_nx;
      rst_req <= req_nx;
    end
  end

  assign dbg_state = {~cs_sync[1], sclk_s, stage};
endmodule

// File: rtl/sclk_reset_detector_chk.sv
`timescale 1ns/1ps
module sclk_reset_detector_chk #(
  parameter int CNT_W   = 11,
  parameter int CNT_MAX = 2001
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_req,
  input logic [3:0]       dbg_state,
  input logic [CNT_W-1:0] cnt
);
  assert_req_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_req_after_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (!$past(dbg_state[2]) && $past(dbg_state[2], 2)));

  assert_req_from_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(dbg_state[1:0]) == 2'd2 && dbg_state[1:0] == 2'd0));

  assert_stage_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_state[1:0] != 2'd3);

  assert_stage_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_state[1:0] == 2'd2 |-> $past(dbg_state[1:0]) != 2'd0);

  assert_advance_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state[1:0] != 2'd0 && dbg_state[1:0] != $past(dbg_state[1:0]))
      |-> ($past(dbg_state[2], 2) && !$past(dbg_state[2])));

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= CNT_MAX);

  assert_cnt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) == CNT_MAX |=> (int'(cnt) == CNT_MAX || int'(cnt) == 1));
endmodule

bind sclk_reset_detector sclk_reset_detector_chk #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .dbg_state(dbg_state), .cnt(cnt)
);

// File: tb/sim_sclk_reset_detector.sv
`timescale 1ns/1ps
module sim_sclk_reset_detector;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0;
  logic rst_req;
  logic [3:0] dbg;

  sclk_reset_detector u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_in(sclk),
                          .rst_req(rst_req), .dbg_state(dbg));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int req_seen = 0, exp_req = 0, model_stage = 0, last_low = 100;
  bit prev_req = 1'b0;
  bit done = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_req) req_seen++;
      if (rst_req && prev_req) check("R5 request wider than one cycle", 2, 1);
      prev_req = rst_req;
    end
  end

  function automatic bit inw(input int w, input int lo, input int hi);
    return (w >= lo) && (w <= hi);
  endfunction

  function automatic int next_stage(input int st, input int lowlen, input int hi, output bit fire);
    int s = st;
    fire = 1'b0;
    if (s != 0 && lowlen < 5) s = 0;
    case (s)
      1: s = inw(hi, 550, 750) ? 2 : (inw(hi, 300, 500) ? 1 : 0);
      2: if (inw(hi, 1050, 1250)) begin fire = 1'b1; s = 0; end
         else s = inw(hi, 300, 500) ? 1 : 0;
      default: s = inw(hi, 300, 500) ? 1 : 0;
    endcase
    return s;
  endfunction

  task automatic pulse(input int hi, input int lo, input string tag);
    bit fire;
    model_stage = next_stage(model_stage, last_low, hi, fire);
    if (fire) exp_req++;
    sclk = 1'b1;
    repeat (hi) @(negedge clk);
    sclk = 1'b0;
    repeat (lo) @(negedge clk);
    last_low = lo;
    if (lo > 2000) model_stage = 0;
    if (lo >= 4 && !(lo >= 1990 && lo <= 2010)) begin
      check({tag, " R11 progress"}, int'(dbg[1:0]), model_stage);
      check({tag, " R5 request count"}, req_seen, exp_req);
      check({tag, " R9 selected flag"}, int'(dbg[3]), int'(!cs_n));
      check({tag, " R1 synced level"}, int'(dbg[2]), 0);
    end
  endtask

  task automatic pattern(input int a, input int b, input int c, input int lo, input string tag);
    pulse(a, lo, tag);
    pulse(b, lo, tag);
    pulse(c, lo, tag);
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check("R10 request in reset", int'(rst_req), 0);
    check("R10 debug in reset", int'(dbg), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 request after reset", int'(rst_req), 0);
    check("R10 debug after reset", int'(dbg), 0);

    pattern(400, 600, 1100, 5, "R2 R4 R5 nominal");
    pattern(300, 550, 1050, 5, "R2 R4 R5 lower edges");
    pattern(500, 750, 1250, 10, "R2 R4 R5 upper edges");
    pattern(299, 600, 1100, 10, "R2 short first");
    pattern(501, 600, 1100, 10, "R2 long first");
    pattern(400, 549, 1100, 10, "R4 short second");
    pattern(400, 751, 1100, 10, "R4 long second");
    pattern(400, 600, 1049, 10, "R5 short third");
    pattern(400, 600, 1251, 10, "R5 long third");
    pulse(400, 4, "R3 short gap");
    pulse(600, 10, "R3 gap abort");
    pulse(400, 4, "R3 short gap");
    pulse(400, 10, "R3 new attempt");
    pulse(600, 10, "R3 continue");
    pulse(1100, 10, "R3 complete");
    pulse(400, 10, "R6 first");
    pulse(400, 10, "R6 restart");
    pulse(600, 10, "R6 second");
    pulse(1100, 10, "R6 third");
    pulse(400, 2000, "R7 gap at limit");
    pulse(600, 10, "R7 kept");
    pulse(1100, 10, "R7 kept done");
    pulse(400, 2001, "R7 gap over limit");
    pulse(600, 10, "R7 aborted");
    pulse(1100, 10, "R7 aborted done");
    pattern(2448, 600, 1100, 10, "R8 saturation");

    cs_n = 1'b0;
    pattern(450, 700, 1200, 8, "R9 selected");
    cs_n = 1'b1;

    pulse(400, 10, "R5 latency first");
    pulse(600, 10, "R5 latency second");
    begin
      bit fire;
      model_stage = next_stage(model_stage, last_low, 1100, fire);
      if (fire) exp_req++;
      sclk = 1'b1;
      @(negedge clk); check("R1 level after one edge", int'(dbg[2]), 0);
      @(negedge clk); check("R1 level after two edges", int'(dbg[2]), 1);
      repeat (1098) @(negedge clk);
      sclk = 1'b0;
      @(negedge clk); check("R5 latency edge 1", int'(rst_req), 0);
      @(negedge clk); check("R5 latency edge 2", int'(rst_req), 0);
      @(negedge clk); check("R5 latency edge 3", int'(rst_req), 1);
      @(negedge clk); check("R5 latency edge 4", int'(rst_req), 0);
      repeat (6) @(negedge clk);
      last_low = 10;
      check("R5 latency count", req_seen, exp_req);
    end

    for (int i = 0; i < 60; i++) begin
      int kind, hi, lo;
      kind = int'($urandom_range(0, 10));
      lo = ($urandom_range(0, 9) == 0) ? 2500 : int'($urandom_range(1, 12));
      cs_n = 1'($urandom_range(0, 1));
      case (kind)
        0, 1, 2, 3: hi = int'($urandom_range(1, 12));
        4: hi = int'($urandom_range(280, 520));
        5: hi = int'($urandom_range(530, 770));
        6: hi = int'($urandom_range(1030, 1270));
        7: hi = int'($urandom_range(300, 500));
        8: hi = int'($urandom_range(550, 750));
        9: hi = int'($urandom_range(1050, 1250));
        default: hi = 0;
      endcase
      if (kind == 10)
        pattern(int'($urandom_range(300, 500)), int'($urandom_range(550, 750)),
                int'($urandom_range(1050, 1250)), int'($urandom_range(5, 20)), "R6 random pattern");
      else
        pulse(hi, lo, "R6 random");
    end

    check("R5 final request count", req_seen, exp_req);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check("R10 watchdog expired", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule